// File: doc/BRIEF.md
# Slotted Shared-Memory Circular Queue Controller

This block runs one circular message queue that lives in a RAM shared by two agents. The RAM is cut into equal slots whose size is a power of two (at least 64 bytes). Slot 0 holds the read pointer (head) and slot 1 holds the write pointer (tail). All later slots carry messages. Both pointers count message slots, so a pointer value of k selects absolute slot k+2. No wrap flag exists. One message slot is always left unused, so the queue holds at most (slots − 3) messages.

A local client starts an enqueue or a dequeue with a one-cycle pulse. The controller first reads both pointers from RAM, because the peer agent may have moved them. It then checks for room or content. It then moves one whole slot-sized message word by word, and only after that writes the advanced pointer back. A request that cannot be served ends with an error pulse and leaves memory untouched. The controller reaches the RAM through a single word-wide port with a one-cycle read latency.

Top module: `shmq_ctrl`

## Requirements
- R1: After reset q_empty is 1, q_full is 0, busy is 0, and neither mem_re nor mem_we is asserted.
- R2: Word w of message slot k is at byte address BASE_ADDR + (k+2)·SLOT_BYTES + 4·w. The head pointer is the 32-bit word at BASE_ADDR and the tail pointer is the word at BASE_ADDR + SLOT_BYTES. Words are little-endian: bit 0 of a word is bit 0 of the byte at its lowest address.
- R3: Every accepted request first reads the head word and then, on the next cycle, the tail word. Read data is valid on mem_rdata one cycle after mem_re.
- R4: An enqueue that finds room writes all SLOT_BYTES/4 words of enq_data, indexed by enq_idx, into the slot named by tail. It then writes (tail+1) mod (SLOT_CNT−2) to the tail word, with enq_done high in the cycle of that last write.
- R5: A dequeue that finds data presents every word of the slot named by head on deq_data, with deq_valid high and deq_idx giving the word number. It then writes (head+1) mod (SLOT_CNT−2) to the head word, with deq_done high.
- R6: An enqueue that finds (tail+1) mod (SLOT_CNT−2) equal to head raises op_err for one cycle and performs no memory write.
- R7: A dequeue that finds head equal to tail raises op_err for one cycle, performs no memory write and presents no data.
- R8: After an operation ends, q_empty equals (head == tail) and q_full equals ((tail+1) mod (SLOT_CNT−2) == head), using the pointer values held in memory at that point.
- R9: If enq_start and deq_start arrive together while idle, only the enqueue is served. Start pulses seen while busy are ignored.
- R10: Pointers wrap from SLOT_CNT−3 to 0.
- R11: A pointer that the peer agent changes in memory between operations governs the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_start | input | 1 | Pulse: begin an enqueue |
| enq_data | input | 32 | Message word selected by enq_idx |
| enq_idx | output | WORD_W | Word number of the message being written |
| enq_done | output | 1 | Pulse: enqueue committed |
| deq_start | input | 1 | Pulse: begin a dequeue |
| deq_data | output | 32 | Dequeued message word |
| deq_idx | output | WORD_W | Word number of deq_data |
| deq_valid | output | 1 | deq_data holds a message word |
| deq_done | output | 1 | Pulse: dequeue committed |
| op_err | output | 1 | Pulse: request refused (full or empty) |
| busy | output | 1 | An operation is in progress |
| q_empty | output | 1 | Queue seen empty |
| q_full | output | 1 | Queue seen full |
| mem_addr | output | ADDR_W | Byte address to shared RAM |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_re |

## Verification
A wrong pointer capture shows up within the same operation. Message words land in, or come from, the wrong slot, and the pointer written back is off. Both appear in the RAM image and on deq_data before the done pulse. A wrong full or empty decision turns a done into op_err, or the reverse, three cycles after the start pulse. The flags show that decision one cycle later. A commit that comes too early shows as a pointer write that is not the last write of the operation, or as fewer than SLOT_BYTES/4 data words.

// File: rtl/shmq_pkg.sv
package shmq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_HEAD,
    ST_RD_TAIL,
    ST_CHECK,
    ST_MOVE,
    ST_COMMIT
  } shmq_state_e;

  // advance a message-slot pointer with wrap
  function automatic logic [31:0] shmq_wrap_inc(input logic [31:0] idx,
                                                input int unsigned n);
    if (idx + 32'd1 >= 32'(n)) return 32'd0;
    return idx + 32'd1;
  endfunction

  // byte address of a word inside an absolute slot
  function automatic logic [31:0] shmq_slot_addr(input logic [31:0] base,
                                                 input logic [31:0] slot,
                                                 input logic [31:0] word,
                                                 input int unsigned slot_sh);
    return base + (slot << slot_sh) + (word << 2);
  endfunction

endpackage

// File: rtl/shmq_addr.sv
module shmq_addr #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned BASE_ADDR  = 0,
  parameter int unsigned SLOT_BYTES = 64
) (
  input  logic [31:0]       slot,
  input  logic [31:0]       word,
  output logic [ADDR_W-1:0] addr
);
  import shmq_pkg::*;
  localparam int unsigned SLOT_SH = $clog2(SLOT_BYTES);

  logic [31:0] full_addr;
  assign full_addr = shmq_slot_addr(32'(BASE_ADDR), slot, word, SLOT_SH);
  assign addr      = full_addr[ADDR_W-1:0];
endmodule

// File: rtl/shmq_occupancy.sv
module shmq_occupancy #(
  parameter int unsigned MSG_SLOTS = 4
) (
  input  logic [31:0] head,
  input  logic [31:0] tail,
  output logic        is_empty,
  output logic        is_full
);
  import shmq_pkg::*;
  assign is_empty = (head == tail);
  assign is_full  = (shmq_wrap_inc(tail, MSG_SLOTS) == head);
endmodule

// File: rtl/shmq_word_ctr.sv
module shmq_word_ctr #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned LAST  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc)      cnt <= cnt + 1'b1;
  end
  assign at_last = (cnt == CNT_W'(LAST));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(LAST) && inc) |=> (cnt == '0));
endmodule

// File: rtl/shmq_ctrl.sv
module shmq_ctrl #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned BASE_ADDR  = 0,
  parameter int unsigned SLOT_BYTES = 64,
  parameter int unsigned SLOT_CNT   = 6,
  localparam int unsigned WORDS     = SLOT_BYTES / 4,
  localparam int unsigned WORD_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_start,
  input  logic [31:0]       enq_data,
  output logic [WORD_W-1:0] enq_idx,
  output logic              enq_done,
  input  logic              deq_start,
  output logic [31:0]       deq_data,
  output logic [WORD_W-1:0] deq_idx,
  output logic              deq_valid,
  output logic              deq_done,
  output logic              op_err,
  output logic              busy,
  output logic              q_empty,
  output logic              q_full,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  import shmq_pkg::*;

  localparam int unsigned MSG_SLOTS = SLOT_CNT - 2;
  localparam logic [ADDR_W-1:0] HEAD_ADDR = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] TAIL_ADDR = ADDR_W'(BASE_ADDR + SLOT_BYTES);

  shmq_state_e       state_q;
  logic              op_enq_q;
  logic [31:0]       head_q, tail_q;
  logic              rd_pend_q;
  logic [WORD_W-1:0] rd_idx_q;
  logic              empty_q, full_q;

  // named internal events
  logic in_move, in_commit, in_check;
  logic pre_empty, pre_full, post_empty, post_full, reject;
  logic [31:0] tail_view, head_nxt, tail_nxt, head_post, tail_post;
  logic [31:0] slot_sel, word_sel;
  logic [WORD_W-1:0] wcnt;
  logic wlast;

  assign in_move   = (state_q == ST_MOVE);
  assign in_commit = (state_q == ST_COMMIT);
  assign in_check  = (state_q == ST_CHECK);

  assign tail_view = in_check ? mem_rdata : tail_q;
  assign head_nxt  = shmq_wrap_inc(head_q, MSG_SLOTS);
  assign tail_nxt  = shmq_wrap_inc(tail_q, MSG_SLOTS);
  assign head_post = op_enq_q ? head_q : head_nxt;
  assign tail_post = op_enq_q ? tail_nxt : tail_q;

  shmq_occupancy #(.MSG_SLOTS(MSG_SLOTS)) u_occ_pre (
    .head(head_q), .tail(tail_view), .is_empty(pre_empty), .is_full(pre_full));
  shmq_occupancy #(.MSG_SLOTS(MSG_SLOTS)) u_occ_post (
    .head(head_post), .tail(tail_post), .is_empty(post_empty), .is_full(post_full));

  assign reject = op_enq_q ? pre_full : pre_empty;

  shmq_word_ctr #(.CNT_W(WORD_W), .LAST(WORDS - 1)) u_wctr (
    .clk(clk), .rst_n(rst_n), .clr(!in_move), .inc(in_move),
    .cnt(wcnt), .at_last(wlast));

  always_comb begin
    slot_sel = 32'd0;
    unique case (state_q)
      ST_RD_TAIL: slot_sel = 32'd1;
      ST_MOVE:    slot_sel = (op_enq_q ? tail_q : head_q) + 32'd2;
      ST_COMMIT:  slot_sel = op_enq_q ? 32'd1 : 32'd0;
      default:    slot_sel = 32'd0;
    endcase
  end
  assign word_sel = in_move ? 32'(wcnt) : 32'd0;

  shmq_addr #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .SLOT_BYTES(SLOT_BYTES)) u_addr (
    .slot(slot_sel), .word(word_sel), .addr(mem_addr));

  assign mem_re    = (state_q == ST_RD_HEAD) || (state_q == ST_RD_TAIL) || (in_move && !op_enq_q);
  assign mem_we    = (in_move && op_enq_q) || in_commit;
  assign mem_wdata = in_commit ? (op_enq_q ? tail_nxt : head_nxt) : enq_data;

  assign enq_idx   = wcnt;
  assign deq_valid = rd_pend_q;
  assign deq_idx   = rd_idx_q;
  assign deq_data  = mem_rdata;
  assign enq_done  = in_commit && op_enq_q;
  assign deq_done  = in_commit && !op_enq_q;
  assign op_err    = in_check && reject;
  assign busy      = (state_q != ST_IDLE);
  assign q_empty   = empty_q;
  assign q_full    = full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_enq_q  <= 1'b0;
      head_q    <= '0;
      tail_q    <= '0;
      rd_pend_q <= 1'b0;
      rd_idx_q  <= '0;
      empty_q   <= 1'b1;
      full_q    <= 1'b0;
    end else begin
      rd_pend_q <= in_move && !op_enq_q;
      rd_idx_q  <= wcnt;
      unique case (state_q)
        ST_IDLE: begin
          if (enq_start) begin
            op_enq_q <= 1'b1;
            state_q  <= ST_RD_HEAD;
          end else if (deq_start) begin
            op_enq_q <= 1'b0;
            state_q  <= ST_RD_HEAD;
          end
        end
        ST_RD_HEAD: state_q <= ST_RD_TAIL;
        ST_RD_TAIL: begin
          head_q  <= mem_rdata;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          tail_q  <= mem_rdata;
          empty_q <= pre_empty;
          full_q  <= pre_full;
          state_q <= reject ? ST_IDLE : ST_MOVE;
        end
        ST_MOVE: if (wlast) state_q <= ST_COMMIT;
        ST_COMMIT: begin
          empty_q <= post_empty;
          full_q  <= post_full;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> !mem_we);
  // R7
  err_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |=> !deq_valid);
  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_empty && q_full));
  // R9
  single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enq_done, deq_done, op_err}));
  // R3
  open_with_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_re && mem_addr == HEAD_ADDR));
  // R5
  deq_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid |-> $past(mem_re));
  // R10
  index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (enq_done || deq_done) && (mem_addr == HEAD_ADDR || mem_addr == TAIL_ADDR))
      |-> (mem_wdata < 32'(MSG_SLOTS)));
  // R1
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));
endmodule

// File: tb/shmq_ctrl_bench.sv
`timescale 1ns/1ps
module shmq_ctrl_bench;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned SB     = 64;
  localparam int unsigned SC     = 6;
  localparam int unsigned W      = SB / 4;
  localparam int unsigned MS     = SC - 2;
  localparam int unsigned MW     = SC * W;
  localparam int unsigned WW     = $clog2(W);

  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_start = 1'b0, deq_start = 1'b0;
  logic [31:0] enq_data, deq_data, mem_wdata, mem_rdata;
  logic [WW-1:0] enq_idx, deq_idx;
  logic enq_done, deq_done, deq_valid, op_err, busy, q_empty, q_full, mem_re, mem_we;
  logic [ADDR_W-1:0] mem_addr;

  always #10 clk = ~clk;

  shmq_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(0), .SLOT_BYTES(SB), .SLOT_CNT(SC)) u_shmq_ctrl (
    .clk(clk), .rst_n(rst_n), .enq_start(enq_start), .enq_data(enq_data), .enq_idx(enq_idx),
    .enq_done(enq_done), .deq_start(deq_start), .deq_data(deq_data), .deq_idx(deq_idx),
    .deq_valid(deq_valid), .deq_done(deq_done), .op_err(op_err), .busy(busy),
    .q_empty(q_empty), .q_full(q_full), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  // message source
  logic [31:0] enq_msg [W];
  assign enq_data = enq_msg[enq_idx];

  // shared RAM model, plus a back door for the peer agent
  logic [31:0] mem [MW];
  logic        bk_we = 1'b0;
  int unsigned bk_word = 0;
  logic [31:0] bk_data = '0;
  int unsigned wr_cnt, rd_cnt;
  logic [ADDR_W-1:0] last_wr;
  logic [ADDR_W-1:0] rd_log [64];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MW; i++) mem[i] <= '0;
      mem_rdata <= '0;
      wr_cnt <= 0;
      rd_cnt <= 0;
      last_wr <= '0;
    end else begin
      if (bk_we) mem[bk_word] <= bk_data;
      if (mem_we) begin
        mem[int'(mem_addr >> 2)] <= mem_wdata;
        wr_cnt  <= wr_cnt + 1;
        last_wr <= mem_addr;
      end
      if (mem_re) begin
        mem_rdata <= mem[int'(mem_addr >> 2)];
        rd_log[rd_cnt % 64] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  // dequeued data capture
  logic [31:0] dq_buf [W];
  int unsigned dq_cnt = 0;
  always @(negedge clk) begin
    if (deq_valid) begin
      dq_buf[deq_idx] <= deq_data;
      dq_cnt <= dq_cnt + 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  function automatic int unsigned nxt(input int unsigned i);
    return (i + 1) % MS;
  endfunction
  function automatic int unsigned word_of(input int unsigned k, input int unsigned w);
    return (k + 2) * W + w; // R2 address rule, in words
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bk_write(input int unsigned word, input logic [31:0] d);
    @(negedge clk);
    bk_we = 1'b1; bk_word = word; bk_data = d;
    @(negedge clk);
    bk_we = 1'b0;
  endtask

  // one operation, expectations from the RAM image before it starts
  task automatic do_op(input bit want_enq, input bit both, input string tag);
    int unsigned h, t, wr0, rd0, dq0, nh, nt;
    bit exp_err, got_done, got_enq, got_err, hung;
    logic [31:0] snap [MW];
    h = mem[0]; t = mem[W];
    for (int i = 0; i < MW; i++) snap[i] = mem[i];
    exp_err = want_enq ? (nxt(t) == h) : (h == t);
    for (int i = 0; i < W; i++) enq_msg[i] = $urandom;
    wr0 = wr_cnt; rd0 = rd_cnt; dq0 = dq_cnt;
    @(negedge clk);
    enq_start = want_enq | both;
    deq_start = ~want_enq | both;
    @(negedge clk);
    enq_start = 1'b0; deq_start = 1'b0;
    hung = 1'b1; got_done = 0; got_enq = 0; got_err = 0;
    for (int n = 0; n < 200; n++) begin
      if (enq_done || deq_done || op_err) begin
        got_done = enq_done | deq_done; got_enq = enq_done; got_err = op_err;
        hung = 1'b0;
        break;
      end
      @(negedge clk);
    end
    chk(!hung, tag, "operation finished", 32'(hung), 32'd0);
    @(negedge clk);
    chk(rd_log[rd0 % 64] == 0 && rd_log[(rd0 + 1) % 64] == ADDR_W'(SB), "R3",
        "pointer reads head then tail", 32'(rd_log[(rd0 + 1) % 64]), SB);
    if (exp_err) begin
      chk(got_err && !got_done, want_enq ? "R6" : "R7", "refusal pulse",
          {30'd0, got_err, got_done}, 32'd2);
      chk(wr_cnt == wr0, want_enq ? "R6" : "R7", "no write", wr_cnt - wr0, 0);
      chk(dq_cnt == dq0, "R7", "no data words", dq_cnt - dq0, 0);
      for (int i = 0; i < MW; i++)
        if (mem[i] != snap[i]) chk(0, "R6", "memory changed", mem[i], snap[i]);
    end else if (want_enq) begin
      chk(got_done && got_enq, both ? "R9" : "R4", "enqueue done", {31'd0, got_enq}, 1);
      chk(wr_cnt - wr0 == W + 1, "R4", "write count", wr_cnt - wr0, W + 1);
      chk(last_wr == ADDR_W'(SB), "R4", "tail written last", 32'(last_wr), SB);
      for (int i = 0; i < W; i++)
        if (mem[word_of(t, i)] != enq_msg[i])
          chk(0, "R2", "slot word", mem[word_of(t, i)], enq_msg[i]);
      chk(mem[W] == nxt(t), "R4", "tail advanced", mem[W], nxt(t));
      chk(mem[0] == h, "R9", "head untouched", mem[0], h);
    end else begin
      chk(got_done && !got_enq, "R5", "dequeue done", {31'd0, got_done}, 1);
      chk(dq_cnt - dq0 == W, "R5", "data word count", dq_cnt - dq0, W);
      for (int i = 0; i < W; i++)
        if (dq_buf[i] != snap[word_of(h, i)])
          chk(0, "R5", "dequeued word", dq_buf[i], snap[word_of(h, i)]);
      chk(wr_cnt - wr0 == 1 && last_wr == 0, "R5", "only head written",
          wr_cnt - wr0, 1);
      chk(mem[0] == nxt(h), "R5", "head advanced", mem[0], nxt(h));
    end
    nh = mem[0]; nt = mem[W];
    chk(q_empty == (nh == nt), "R8", "empty flag", 32'(q_empty), 32'(nh == nt));
    chk(q_full == (nxt(nt) == nh), "R8", "full flag", 32'(q_full), 32'(nxt(nt) == nh));
  endtask

  initial begin
    int unsigned seed_sink, r, t0, h0;
    seed_sink = $urandom(32'd4711);
    for (int i = 0; i < W; i++) enq_msg[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(q_empty == 1'b1 && q_full == 1'b0, "R1", "flags in reset", {30'd0, q_empty, q_full}, 2);
    chk(!busy && !mem_we && !mem_re, "R1", "idle in reset", {29'd0, busy, mem_we, mem_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && q_empty, "R1", "idle after reset", {30'd0, busy, q_empty}, 1);

    do_op(1'b0, 1'b0, "R7");                 // dequeue from empty
    for (int i = 0; i < MS - 1; i++) do_op(1'b1, 1'b0, "R4");
    chk(q_full, "R6", "full after fill", 32'(q_full), 1);
    do_op(1'b1, 1'b0, "R6");                 // enqueue into full
    for (int i = 0; i < MS - 1; i++) do_op(1'b0, 1'b0, "R5");
    // head = tail = MS-1: next enqueue wraps tail to 0
    t0 = mem[W];
    do_op(1'b1, 1'b0, "R10");
    chk(t0 == MS - 1 && mem[W] == 0, "R10", "tail wraps", mem[W], 0);
    do_op(1'b0, 1'b0, "R10");
    chk(mem[0] == 0, "R10", "head wraps", mem[0], 0);
    // both starts together
    do_op(1'b1, 1'b1, "R9");
    // peer producer: place a message and advance tail in memory
    t0 = mem[W];
    for (int i = 0; i < W; i++) bk_write(word_of(t0, i), 32'hA500_0000 + i);
    bk_write(W, nxt(t0));
    do_op(1'b0, 1'b0, "R11");
    do_op(1'b0, 1'b0, "R11");
    chk(dq_buf[3] == 32'hA500_0003, "R11", "peer message seen", dq_buf[3], 32'hA500_0003);
    // random traffic with peer consumer steps
    for (int k = 0; k < 80; k++) begin
      r = $urandom % 8;
      if (r < 4) do_op(1'b1, 1'b0, "R4");
      else if (r < 7) do_op(1'b0, 1'b0, "R5");
      else begin
        h0 = mem[0];
        if (h0 != mem[W]) bk_write(0, nxt(h0));
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule